// File: doc/BRIEF.md
# Message time tag counter

This block keeps a 16-bit free-running time base for a serial bus terminal. Every processed message is stamped with it. The count advances from one of several sources, picked by a select input:

- an internal tick whose period is a whole number of microseconds (2, 4, 8, 16, 32 or 64 µs per count);
- the rising edges of an asynchronous external clock pin;
- a software strobe, used to self-test the counter;
- no source at all, which freezes the count.

The host reads the count at all times and can overwrite it. A host reset command clears it.

The protocol decoder drives two requests into the block. A synchronize command without data clears the count, and a synchronize command with data loads the count from its data word. Each request has its own enable. When the count wraps from 0xFFFF to 0x0000, the block raises a one-cycle rollover event, which the interrupt logic turns into a request and a status bit.

When a message completes, the block captures the count and presents it on a valid/ready stream, which the descriptor writer consumes. The held word stays still while the consumer stalls. A completion that arrives while an earlier stamp is still stalled is dropped, so the consumer always receives the oldest pending stamp and is never overrun.

Top module: `msg_timetag`

## Requirements
- R1: After an active-low reset, `host_rd_data` is 0, `rollover` is low and `cap_valid` is low.
- R2: `host_rd_data` always shows the count. When `host_wr` is high at a clock edge, the count equals `host_wdata` after that edge, whatever other request is active in the same cycle (top priority).
- R3: With `src_sel`=0, the count advances once every `CLKS_PER_US`·2^(k+1) clocks, where k is `res_sel` (0..5). Codes 6 and 7 act as code 5. A `soft_reset` restarts the tick phase, so the first advance comes exactly one period after the reset edge.
- R4: With `src_sel`=1, the count advances once for each rising edge of `ext_clk`. The advance lands on the third clock edge after `ext_clk` is first sampled high. A level held high does not advance the count again.
- R5: With `src_sel`=2, each cycle with `sw_inc` high advances the count by one. `sw_inc` has no effect under any other select value. With `src_sel`=3 the count does not advance.
- R6: `soft_reset` clears the count. It ranks below a host write and above the synchronize requests and the increment.
- R7: `sync_data_vld` with `sync_ld_en` high loads `sync_data` into the count. With `sync_ld_en` low the request is ignored. The load ranks above the synchronize clear.
- R8: `sync_nodata` with `sync_clr_en` high clears the count. With `sync_clr_en` low the request is ignored. The clear ranks above the increment.
- R9: `rollover` is high for exactly the one cycle in which the count first reads 0 after an increment from 0xFFFF. Host writes, loads and clears never raise it.
- R10: A `msg_done` pulse, taken while the output slot is empty or being accepted in the same cycle, makes `cap_valid` high in the next cycle, with `cap_data` equal to the count seen in the `msg_done` cycle.
- R11: While `cap_valid` is high and `cap_ready` is low, `cap_valid` and `cap_data` hold, and any `msg_done` is dropped. `cap_valid` falls after the accepting cycle unless a new capture is taken in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_sel | input | 2 | Increment source: 0 tick, 1 external, 2 software, 3 none |
| res_sel | input | 3 | Tick resolution code k: 2^(k+1) µs per count |
| ext_clk | input | 1 | Asynchronous external increment clock |
| sw_inc | input | 1 | Software increment strobe |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 16 | Host write value |
| host_rd_data | output | 16 | Current count |
| soft_reset | input | 1 | Host reset command for the counter |
| sync_ld_en | input | 1 | Enables load on synchronize-with-data |
| sync_data_vld | input | 1 | Synchronize-with-data request |
| sync_data | input | 16 | Data word of that command |
| sync_clr_en | input | 1 | Enables clear on synchronize-without-data |
| sync_nodata | input | 1 | Synchronize-without-data request |
| msg_done | input | 1 | Message processed, capture the count |
| cap_valid | output | 1 | Captured stamp available |
| cap_ready | input | 1 | Consumer accepts the stamp |
| cap_data | output | 16 | Captured stamp |
| rollover | output | 1 | One-cycle wrap event |

## Verification
The count is driven in turn by single and spaced software strobes, by internal ticks at all eight resolution codes, and by external edges of long, short and single-cycle width. This separates a wrong tick period or a missed code saturation from a missed or double-counted edge. Cycles that stack a host write, a reset, a load and a clear expose any wrong priority order. Writing or loading 0xFFFF before an increment, and before a plain write of zero, separates a true wrap from a mere transition to zero. On the capture stream, completions arrive against ready held high, against a stall, and against an accept in the same cycle, which shows whether stamps are dropped, overwritten or held correctly.

// File: rtl/msg_timetag_pkg.sv
`timescale 1ns/1ps
package msg_timetag_pkg;

  // Increment source selected by src_sel
  typedef enum logic [1:0] {
    TT_SRC_TICK = 2'd0,
    TT_SRC_EXT  = 2'd1,
    TT_SRC_SOFT = 2'd2,
    TT_SRC_OFF  = 2'd3
  } tt_src_e;

  // Highest meaningful resolution code; larger codes saturate to it
  localparam int unsigned TT_RES_TOP = 5;

  // Winning update for the count in one cycle
  typedef enum logic [2:0] {
    UPD_HOLD,
    UPD_HOST,
    UPD_RST,
    UPD_LOAD,
    UPD_CLEAR,
    UPD_INC
  } tt_upd_e;

endpackage

// File: rtl/mtt_tick_gen.sv
`timescale 1ns/1ps
module mtt_tick_gen
  import msg_timetag_pkg::*;
#(
  parameter int unsigned CLKS_PER_US = 16,
  parameter int unsigned RES_W       = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [RES_W-1:0] res_sel,
  output logic             tick
);

  localparam int unsigned LIM_MAX = CLKS_PER_US * 64;
  localparam int unsigned PRE_W   = $clog2(LIM_MAX + 1);

  logic [RES_W-1:0] eff_code;
  logic [PRE_W-1:0] limit;
  logic [PRE_W-1:0] pre_q;
  int unsigned      span;

  // Period in clocks for the chosen resolution, codes above the top saturate
  always_comb begin
    eff_code = (res_sel > RES_W'(TT_RES_TOP)) ? RES_W'(TT_RES_TOP) : res_sel;
    span     = CLKS_PER_US << (32'(eff_code) + 32'd1);
    limit    = PRE_W'(span - 32'd1);
  end

  assign tick = (pre_q >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else if (restart || tick) begin
      pre_q <= '0;
    end else begin
      pre_q <= pre_q + PRE_W'(1);
    end
  end

endmodule

// File: rtl/mtt_edge_sync.sv
`timescale 1ns/1ps
module mtt_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);

  logic [STAGES-1:0] chain_q;
  logic              last_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[0] <= 1'b0;
        else        chain_q[0] <= async_in;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[i] <= 1'b0;
        else        chain_q[i] <= chain_q[i-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= chain_q[STAGES-1];
  end

  assign rise = chain_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/mtt_count_core.sv
`timescale 1ns/1ps
module mtt_count_core
  import msg_timetag_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         host_wr,
  input  logic [W-1:0] host_wdata,
  input  logic         rst_req,
  input  logic         ld_req,
  input  logic [W-1:0] ld_data,
  input  logic         clr_req,
  input  logic         inc,
  output logic [W-1:0] count,
  output logic         wrap
);

  tt_upd_e      upd;
  logic [W-1:0] count_q;
  logic         wrap_q;

  // Fixed priority: host write, reset, sync load, sync clear, increment
  always_comb begin
    if (host_wr)      upd = UPD_HOST;
    else if (rst_req) upd = UPD_RST;
    else if (ld_req)  upd = UPD_LOAD;
    else if (clr_req) upd = UPD_CLEAR;
    else if (inc)     upd = UPD_INC;
    else              upd = UPD_HOLD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      wrap_q  <= 1'b0;
    end else begin
      wrap_q <= (upd == UPD_INC) && (count_q == {W{1'b1}});
      unique case (upd)
        UPD_HOST:  count_q <= host_wdata;
        UPD_RST:   count_q <= '0;
        UPD_LOAD:  count_q <= ld_data;
        UPD_CLEAR: count_q <= '0;
        UPD_INC:   count_q <= count_q + W'(1);
        default:   count_q <= count_q;
      endcase
    end
  end

  assign count = count_q;
  assign wrap  = wrap_q;

endmodule

// File: rtl/mtt_capture.sv
`timescale 1ns/1ps
module mtt_capture #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         msg_done,
  input  logic [W-1:0] count,
  output logic         cap_valid,
  input  logic         cap_ready,
  output logic [W-1:0] cap_data
);

  logic         valid_q;
  logic [W-1:0] data_q;
  logic         slot_free;

  assign slot_free = !valid_q || cap_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      if (valid_q && cap_ready) valid_q <= 1'b0;
      if (msg_done && slot_free) begin
        valid_q <= 1'b1;
        data_q  <= count;
      end
    end
  end

  assign cap_valid = valid_q;
  assign cap_data  = data_q;

endmodule

// File: rtl/msg_timetag.sv
`timescale 1ns/1ps
module msg_timetag
  import msg_timetag_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned CLKS_PER_US = 16,
  parameter int unsigned RES_W       = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       src_sel,
  input  logic [RES_W-1:0] res_sel,
  input  logic             ext_clk,
  input  logic             sw_inc,
  input  logic             host_wr,
  input  logic [CNT_W-1:0] host_wdata,
  output logic [CNT_W-1:0] host_rd_data,
  input  logic             soft_reset,
  input  logic             sync_ld_en,
  input  logic             sync_data_vld,
  input  logic [CNT_W-1:0] sync_data,
  input  logic             sync_clr_en,
  input  logic             sync_nodata,
  input  logic             msg_done,
  output logic             cap_valid,
  input  logic             cap_ready,
  output logic [CNT_W-1:0] cap_data,
  output logic             rollover
);

  logic         tick;
  logic         ext_rise;
  logic         inc;
  tt_src_e      src;
  logic [CNT_W-1:0] count;

  assign src = tt_src_e'(src_sel);

  mtt_tick_gen #(
    .CLKS_PER_US (CLKS_PER_US),
    .RES_W       (RES_W)
  ) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (soft_reset),
    .res_sel (res_sel),
    .tick    (tick)
  );

  mtt_edge_sync #(
    .STAGES (SYNC_STAGES)
  ) u_ext (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (ext_clk),
    .rise     (ext_rise)
  );

  always_comb begin
    unique case (src)
      TT_SRC_TICK: inc = tick;
      TT_SRC_EXT:  inc = ext_rise;
      TT_SRC_SOFT: inc = sw_inc;
      default:     inc = 1'b0;
    endcase
  end

  mtt_count_core #(
    .W (CNT_W)
  ) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_wr    (host_wr),
    .host_wdata (host_wdata),
    .rst_req    (soft_reset),
    .ld_req     (sync_data_vld && sync_ld_en),
    .ld_data    (sync_data),
    .clr_req    (sync_nodata && sync_clr_en),
    .inc        (inc),
    .count      (count),
    .wrap       (rollover)
  );

  mtt_capture #(
    .W (CNT_W)
  ) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .msg_done  (msg_done),
    .count     (count),
    .cap_valid (cap_valid),
    .cap_ready (cap_ready),
    .cap_data  (cap_data)
  );

  assign host_rd_data = count;

endmodule

// File: rtl/msg_timetag_chk.sv
`timescale 1ns/1ps
module msg_timetag_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic [1:0]   src_sel,
  input logic         host_wr,
  input logic [W-1:0] host_wdata,
  input logic         soft_reset,
  input logic         sync_ld_en,
  input logic         sync_data_vld,
  input logic [W-1:0] sync_data,
  input logic         sync_clr_en,
  input logic         sync_nodata,
  input logic [W-1:0] host_rd_data,
  input logic         rollover,
  input logic         cap_valid,
  input logic         cap_ready,
  input logic [W-1:0] cap_data
);

  // R2
  host_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr |=> host_rd_data == $past(host_wdata));

  // R6
  soft_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_reset && !host_wr |=> host_rd_data == '0);

  // R7
  sync_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_data_vld && sync_ld_en && !host_wr && !soft_reset
      |=> host_rd_data == $past(sync_data));

  // R5
  src_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_sel == 2'd3 && !host_wr && !soft_reset
      && !(sync_data_vld && sync_ld_en) && !(sync_nodata && sync_clr_en)
      |=> $stable(host_rd_data));

  // R9
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rollover |-> host_rd_data == '0 && $past(host_rd_data) == {W{1'b1}});

  // R11
  cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_valid && !cap_ready |=> cap_valid && $stable(cap_data));

endmodule

bind msg_timetag msg_timetag_chk #(.W(CNT_W)) u_msg_timetag_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .src_sel       (src_sel),
  .host_wr       (host_wr),
  .host_wdata    (host_wdata),
  .soft_reset    (soft_reset),
  .sync_ld_en    (sync_ld_en),
  .sync_data_vld (sync_data_vld),
  .sync_data     (sync_data),
  .sync_clr_en   (sync_clr_en),
  .sync_nodata   (sync_nodata),
  .host_rd_data  (host_rd_data),
  .rollover      (rollover),
  .cap_valid     (cap_valid),
  .cap_ready     (cap_ready),
  .cap_data      (cap_data)
);

// File: tb/test_msg_timetag.sv
`timescale 1ns/1ps
module test_msg_timetag;

  localparam int CPU = 4;
  localparam int MAX_CYCLES = 200000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  src_sel = 2'd3;
  logic [2:0]  res_sel = 3'd0;
  logic        ext_clk = 1'b0;
  logic        sw_inc = 1'b0;
  logic        host_wr = 1'b0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rd_data;
  logic        soft_reset = 1'b0;
  logic        sync_ld_en = 1'b0;
  logic        sync_data_vld = 1'b0;
  logic [15:0] sync_data = '0;
  logic        sync_clr_en = 1'b0;
  logic        sync_nodata = 1'b0;
  logic        msg_done = 1'b0;
  logic        cap_valid;
  logic        cap_ready = 1'b1;
  logic [15:0] cap_data;
  logic        rollover;

  always #2.5 clk = ~clk;

  msg_timetag #(.CLKS_PER_US(CPU)) i_msg_timetag (
    .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .res_sel(res_sel),
    .ext_clk(ext_clk), .sw_inc(sw_inc), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rd_data(host_rd_data),
    .soft_reset(soft_reset), .sync_ld_en(sync_ld_en),
    .sync_data_vld(sync_data_vld), .sync_data(sync_data),
    .sync_clr_en(sync_clr_en), .sync_nodata(sync_nodata),
    .msg_done(msg_done), .cap_valid(cap_valid), .cap_ready(cap_ready),
    .cap_data(cap_data), .rollover(rollover)
  );

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R1";

  // Behavioural reference state
  int m_cnt = 0, m_pre = 0, m_cd = 0, m_old = 0, m_code = 0, m_span = 0;
  bit m_roll = 0, m_cv = 0, m_was_cv = 0, m_tick = 0, m_inc = 0;
  bit m_e1 = 0, m_e2 = 0, m_e3 = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_pre = 0; m_roll = 0; m_cv = 0; m_cd = 0;
      m_e1 = 0; m_e2 = 0; m_e3 = 0;
    end else begin
      m_code = (res_sel > 5) ? 5 : int'(res_sel);
      m_span = CPU * (2 ** (m_code + 1));
      m_tick = (m_pre >= m_span - 1);
      m_inc  = (src_sel == 0 && m_tick) || (src_sel == 1 && m_e2 && !m_e3)
               || (src_sel == 2 && sw_inc);
      m_old  = m_cnt;
      m_roll = 0;
      if (host_wr) m_cnt = int'(host_wdata);
      else if (soft_reset) m_cnt = 0;
      else if (sync_data_vld && sync_ld_en) m_cnt = int'(sync_data);
      else if (sync_nodata && sync_clr_en) m_cnt = 0;
      else if (m_inc) begin
        m_cnt  = (m_old + 1) % 65536;
        m_roll = (m_old == 65535);
      end
      m_was_cv = m_cv;
      if (m_was_cv && cap_ready) m_cv = 0;
      if (msg_done && (!m_was_cv || cap_ready)) begin
        m_cv = 1;
        m_cd = m_old;
      end
      if (soft_reset || m_tick) m_pre = 0;
      else m_pre = m_pre + 1;
      m_e3 = m_e2; m_e2 = m_e1; m_e1 = ext_clk;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Every-cycle comparison against the reference, away from the active edge
  always @(negedge clk) begin
    chk(cur_req, "count", int'(host_rd_data), m_cnt);
    chk(cur_req, "rollover", int'(rollover), int'(m_roll));
    chk(cur_req, "cap_valid", int'(cap_valid), int'(m_cv));
    if (m_cv) chk(cur_req, "cap_data", int'(cap_data), m_cd);
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic hwrite(logic [15:0] v);
    @(negedge clk); host_wr = 1; host_wdata = v;
    @(negedge clk); host_wr = 0;
  endtask

  task automatic srst();
    @(negedge clk); soft_reset = 1;
    @(negedge clk); soft_reset = 0;
  endtask

  task automatic swpulse();
    @(negedge clk); sw_inc = 1;
    @(negedge clk); sw_inc = 0;
  endtask

  task automatic ext_pulse(int hi, int lo);
    @(negedge clk); ext_clk = 1;
    cyc(hi);
    ext_clk = 0;
    cyc(lo);
  endtask

  initial begin
    cyc(3);
    rst_n = 1;
    cyc(1);
    // R1 reset state
    chk("R1", "count", int'(host_rd_data), 0);
    chk("R1", "rollover", int'(rollover), 0);
    chk("R1", "cap_valid", int'(cap_valid), 0);

    // R5 software strobes, then ignored under other selects
    cur_req = "R5";
    src_sel = 2'd2;
    swpulse(); swpulse(); cyc(3); swpulse();
    @(negedge clk); sw_inc = 1; cyc(4); sw_inc = 0;
    cyc(1);
    chk("R5", "count after 7 strobes", int'(host_rd_data), 7);
    src_sel = 2'd3;
    @(negedge clk); sw_inc = 1; cyc(5); sw_inc = 0;
    cyc(1);
    chk("R5", "count frozen when source off", int'(host_rd_data), 7);
    src_sel = 2'd1;
    @(negedge clk); sw_inc = 1; cyc(5); sw_inc = 0;
    cyc(1);
    chk("R5", "strobe ignored under external", int'(host_rd_data), 7);

    // R2 host write and its top priority
    cur_req = "R2";
    src_sel = 2'd3;
    hwrite(16'h1234);
    chk("R2", "written value", int'(host_rd_data), 16'h1234);
    @(negedge clk);
    host_wr = 1; host_wdata = 16'h0BEE; soft_reset = 1;
    sync_ld_en = 1; sync_data_vld = 1; sync_data = 16'h7777;
    sync_clr_en = 1; sync_nodata = 1;
    @(negedge clk);
    host_wr = 0; soft_reset = 0; sync_data_vld = 0; sync_nodata = 0;
    chk("R2", "write beats all", int'(host_rd_data), 16'h0BEE);

    // R6 reset beats sync requests
    cur_req = "R6";
    @(negedge clk);
    soft_reset = 1; sync_data_vld = 1; sync_data = 16'h4444; sync_nodata = 1;
    @(negedge clk);
    soft_reset = 0; sync_data_vld = 0; sync_nodata = 0;
    chk("R6", "reset beats load", int'(host_rd_data), 0);

    // R7 load with enable on and off
    cur_req = "R7";
    @(negedge clk); sync_data_vld = 1; sync_data = 16'hABCD;
    @(negedge clk); sync_data_vld = 0;
    chk("R7", "loaded", int'(host_rd_data), 16'hABCD);
    sync_ld_en = 0;
    @(negedge clk); sync_data_vld = 1; sync_data = 16'h5555;
    @(negedge clk); sync_data_vld = 0;
    chk("R7", "load ignored when disabled", int'(host_rd_data), 16'hABCD);
    sync_ld_en = 1;
    @(negedge clk); sync_data_vld = 1; sync_data = 16'h2468; sync_nodata = 1;
    @(negedge clk); sync_data_vld = 0; sync_nodata = 0;
    chk("R7", "load beats clear", int'(host_rd_data), 16'h2468);

    // R8 clear with enable on and off, and above the increment
    cur_req = "R8";
    sync_clr_en = 0;
    @(negedge clk); sync_nodata = 1;
    @(negedge clk); sync_nodata = 0;
    chk("R8", "clear ignored when disabled", int'(host_rd_data), 16'h2468);
    sync_clr_en = 1; src_sel = 2'd2;
    @(negedge clk); sync_nodata = 1; sw_inc = 1;
    @(negedge clk); sync_nodata = 0; sw_inc = 0;
    chk("R8", "clear beats increment", int'(host_rd_data), 0);

    // R9 wrap from an increment, not from a write or load
    cur_req = "R9";
    hwrite(16'hFFFF);
    swpulse();
    chk("R9", "rollover pulse", int'(rollover), 1);
    cyc(1);
    chk("R9", "rollover one cycle", int'(rollover), 0);
    hwrite(16'hFFFF);
    hwrite(16'h0000);
    chk("R9", "no rollover on write", int'(rollover), 0);
    @(negedge clk); sync_data_vld = 1; sync_data = 16'hFFFF;
    @(negedge clk); sync_data_vld = 0;
    @(negedge clk); sync_nodata = 1;
    @(negedge clk); sync_nodata = 0;
    chk("R9", "no rollover on clear", int'(rollover), 0);

    // R3 internal tick at every resolution code
    cur_req = "R3";
    src_sel = 2'd0;
    for (int code = 0; code < 8; code++) begin
      int span;
      res_sel = 3'(code);
      span = CPU * (2 ** (((code > 5) ? 5 : code) + 1));
      srst();
      cyc(2 * span);
      chk("R3", "ticks after two periods", int'(host_rd_data), 2);
      cyc(span - 1);
      chk("R3", "one clock before third tick", int'(host_rd_data), 2);
      cyc(1);
      chk("R3", "third tick", int'(host_rd_data), 3);
    end

    // R4 external edges of several widths
    cur_req = "R4";
    src_sel = 2'd1;
    srst();
    ext_pulse(6, 4);
    ext_pulse(1, 3);
    ext_pulse(2, 2);
    chk("R4", "three edges", int'(host_rd_data), 3);
    @(negedge clk); ext_clk = 1;
    cyc(2);
    chk("R4", "not yet after two edges", int'(host_rd_data), 3);
    cyc(1);
    chk("R4", "advance on third edge", int'(host_rd_data), 4);
    cyc(20);
    chk("R4", "held level no advance", int'(host_rd_data), 4);
    ext_clk = 0;
    cyc(4);

    // R10 capture with ready high
    cur_req = "R10";
    src_sel = 2'd3;
    cap_ready = 1;
    hwrite(16'h0100);
    @(negedge clk); msg_done = 1;
    @(negedge clk); msg_done = 0;
    chk("R10", "cap_valid", int'(cap_valid), 1);
    chk("R10", "cap_data", int'(cap_data), 16'h0100);
    cyc(1);
    chk("R10", "cap_valid drops after accept", int'(cap_valid), 0);

    // R11 stall, dropped completion, accept with a same-cycle capture
    cur_req = "R11";
    cap_ready = 0;
    hwrite(16'h0200);
    @(negedge clk); msg_done = 1;
    @(negedge clk); msg_done = 0;
    hwrite(16'h0300);
    @(negedge clk); msg_done = 1;
    @(negedge clk); msg_done = 0;
    cyc(3);
    chk("R11", "held data", int'(cap_data), 16'h0200);
    chk("R11", "held valid", int'(cap_valid), 1);
    @(negedge clk); cap_ready = 1; msg_done = 1;
    @(negedge clk); cap_ready = 0; msg_done = 0;
    chk("R11", "new stamp after accept", int'(cap_data), 16'h0300);
    chk("R11", "valid stays", int'(cap_valid), 1);
    @(negedge clk); cap_ready = 1;
    @(negedge clk);
    chk("R11", "valid clears", int'(cap_valid), 0);
    cyc(2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (MAX_CYCLES) @(posedge clk);
    errors++;
    $display("FAIL watchdog %s actual=hung expected=done", cur_req);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule